// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block moves bytes between memory and one I/O device without the processor doing the copying. Software first loads a start address, a byte count and a mode word through a small register port. The controller then waits for the device to request service. In every mode except hidden, it asks the processor for the system bus with a hold request and waits for the acknowledge. Once it owns the bus, it moves one byte per clock cycle. On each byte cycle it drives the memory address, a single read or write strobe and the device acknowledge. After each byte, both the address and the remaining count step down by one.

The mode word sets when the bus is given back to the processor. In block mode it is released only after the last byte. In single mode it is released after every byte and requested again once the processor has taken the bus back. In demand mode it is released whenever the device withdraws its request, and the transfer later resumes from the same address and count. In hidden mode the controller never asks for the bus. It moves bytes only in cycles where the processor reports that it is idle. When the count runs out, the block gives a one-cycle terminal-count pulse and sets a done flag that software can clear.

Top module: `dma_xfer_ctl`

## Requirements
- R1: After reset, hold_req, mem_rd, mem_wr and tc are 0, dev_ack is 1 (inactive, active-low default), and every register reads 0.
- R2: reg_sel selects a register for both write and read: 0 address, 1 count, 2 mode, 3 status. The mode bits are [1:0] policy (0 block, 1 single, 2 demand, 3 hidden), [2] direction and [3] acknowledge polarity. Status bit 0 is done and bit 1 is busy. Writing status with bit 0 set clears done.
- R3: A mode write with bit 4 set starts a transfer only if the count register is nonzero. While busy, writes to the address, count and mode registers have no effect.
- R4: Outside hidden mode, the block raises hold_req only after seeing dev_req high while hold_ack is low. It asserts no memory strobe unless hold_ack is high.
- R5: Each byte cycle asserts exactly one strobe: mem_wr when direction is 1 (device to memory), mem_rd when it is 0. mem_addr carries the current address. After the cycle, the address and the count are each one lower. A transfer of N bytes gives exactly N byte cycles.
- R6: dev_ack is active on byte cycles only. It is active high when mode bit 3 is 1 and active low when it is 0.
- R7: In the cycle after the last byte, tc is high for one cycle, done is set, busy is clear and hold_req is low.
- R8: In block mode, the whole transfer takes a single hold_req tenure.
- R9: In single mode, hold_req is low in the cycle after each byte, and an N-byte transfer takes N tenures.
- R10: In demand mode, no byte moves while dev_req is low. The bus is released, and the count is kept for resumption.
- R11: In hidden mode, hold_req never rises, and a byte moves only in a cycle where both cpu_idle and dev_req are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for write and read |
| reg_wdata | input | HOST_W | Register write data |
| reg_rdata | output | HOST_W | Read data of the selected register |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| cpu_idle | input | 1 | Processor reports no bus use this cycle |
| dev_req | input | 1 | Service request from the device |
| dev_ack | output | 1 | Service acknowledge to the device, polarity set by mode |
| mem_addr | output | ADDR_W | Memory address on byte cycles, 0 otherwise |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| tc | output | 1 | Terminal-count pulse |

## Verification
The bound checker checks these properties on every cycle:
- at most one strobe is active;
- no strobe is active without the grant outside hidden mode;
- the address and count drop by one after every byte and stay frozen while a busy transfer is stalled;
- tc follows a final byte;
- the acknowledge polarity is correct;
- hidden and demand bytes occur only under their gating inputs.

Only the bench scenarios can show the properties that span a whole transfer:
- the total number of bytes and the decreasing address sequence;
- the number of bus tenures for each policy;
- resumption after a demand pause;
- that writes made while busy and a start with a zero count are ignored.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [1:0] {
        POL_BLOCK  = 2'd0,
        POL_SINGLE = 2'd1,
        POL_DEMAND = 2'd2,
        POL_HIDDEN = 2'd3
    } policy_e;

    typedef struct packed {
        logic    dack_hi;
        logic    dev2mem;
        policy_e policy;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_GAP
    } state_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_MODE = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam int MODE_W  = $bits(mode_t);
    localparam int GO_BIT  = MODE_W;

    // Whether a byte may move in a cycle spent in the transfer state.
    function automatic logic byte_allowed(policy_e p, logic dreq, logic idle);
        case (p)
            POL_DEMAND: byte_allowed = dreq;
            POL_HIDDEN: byte_allowed = dreq && idle;
            default:    byte_allowed = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int HOST_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [HOST_W-1:0] reg_wdata,
    output logic [HOST_W-1:0] reg_rdata,
    input  logic              step,
    input  logic              finish,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output mode_t             mode_q,
    output logic              run_q,
    output logic              done_q
);

    logic wr_open;
    assign wr_open = reg_wr && !run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            mode_q <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (wr_open) begin
                case (reg_sel)
                    SEL_ADDR: addr_q <= reg_wdata[ADDR_W-1:0];
                    SEL_CNT:  cnt_q  <= reg_wdata[CNT_W-1:0];
                    SEL_MODE: begin
                        mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
                        if (reg_wdata[GO_BIT] && cnt_q != '0)
                            run_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (reg_wr && reg_sel == SEL_STAT && reg_wdata[0])
                done_q <= 1'b0;
            if (step) begin
                addr_q <= addr_q - ADDR_W'(1);
                cnt_q  <= cnt_q - CNT_W'(1);
            end
            if (finish) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_ADDR: reg_rdata = HOST_W'(addr_q);
            SEL_CNT:  reg_rdata = HOST_W'(cnt_q);
            SEL_MODE: reg_rdata = HOST_W'(mode_q);
            default:  reg_rdata = HOST_W'({run_q, done_q});
        endcase
    end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_xfer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  policy_e policy,
    input  logic    cnt_last,
    input  logic    dev_req,
    input  logic    hold_ack,
    input  logic    cpu_idle,
    output logic    hold_req,
    output logic    move,
    output logic    finish,
    output logic    tc
);

    state_e state_q, state_d;

    assign move     = (state_q == ST_XFER) && byte_allowed(policy, dev_req, cpu_idle);
    assign finish   = move && cnt_last;
    assign hold_req = (state_q == ST_REQ) ||
                      ((state_q == ST_XFER) && policy != POL_HIDDEN);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (run) begin
                    if (policy == POL_HIDDEN) begin
                        if (dev_req && cpu_idle) state_d = ST_XFER;
                    end else if (dev_req && !hold_ack) begin
                        state_d = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (hold_ack) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (!move)                     state_d = ST_IDLE;
                else if (cnt_last)             state_d = ST_IDLE;
                else if (policy == POL_SINGLE) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (!hold_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tc      <= 1'b0;
        end else begin
            state_q <= state_d;
            tc      <= finish;
        end
    end

endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int HOST_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [HOST_W-1:0] reg_wdata,
    output logic [HOST_W-1:0] reg_rdata,
    output logic              hold_req,
    input  logic              hold_ack,
    input  logic              cpu_idle,
    input  logic              dev_req,
    output logic              dev_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              tc
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    mode_t             mode_q;
    logic              run_q;
    logic              done_q;
    logic              move;
    logic              finish;
    logic              cnt_last;

    assign cnt_last = (cnt_q == CNT_W'(1));

    dma_xfer_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .HOST_W (HOST_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .step      (move),
        .finish    (finish),
        .addr_q    (addr_q),
        .cnt_q     (cnt_q),
        .mode_q    (mode_q),
        .run_q     (run_q),
        .done_q    (done_q)
    );

    dma_xfer_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .policy   (mode_q.policy),
        .cnt_last (cnt_last),
        .dev_req  (dev_req),
        .hold_ack (hold_ack),
        .cpu_idle (cpu_idle),
        .hold_req (hold_req),
        .move     (move),
        .finish   (finish),
        .tc       (tc)
    );

    assign mem_rd   = move && !mode_q.dev2mem;
    assign mem_wr   = move &&  mode_q.dev2mem;
    assign mem_addr = move ? addr_q : '0;
    assign dev_ack  = mode_q.dack_hi ? move : !move;

endmodule

// File: rtl/dma_xfer_chk.sv
module dma_xfer_chk
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              hold_req,
    input logic              hold_ack,
    input logic              cpu_idle,
    input logic              dev_req,
    input logic              dev_ack,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              tc,
    input mode_t             mode_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              run_q
);

    logic busy_byte;
    assign busy_byte = mem_rd || mem_wr;

    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r4_strobe_needs_grant: assert property (@(posedge clk) disable iff (rst)
        busy_byte && mode_q.policy != POL_HIDDEN |-> hold_ack && hold_req);

    a_r5_count_steps: assert property (@(posedge clk) disable iff (rst)
        busy_byte |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    a_r5_addr_steps: assert property (@(posedge clk) disable iff (rst)
        busy_byte |=> addr_q == $past(addr_q) - ADDR_W'(1));

    a_r3_frozen_when_stalled: assert property (@(posedge clk) disable iff (rst)
        run_q && !busy_byte |=> $stable(addr_q) && $stable(cnt_q));

    a_r7_tc_after_last: assert property (@(posedge clk) disable iff (rst)
        tc |-> $past(busy_byte) && cnt_q == '0 && !run_q && !hold_req);

    a_r6_ack_level: assert property (@(posedge clk) disable iff (rst)
        busy_byte |-> dev_ack == mode_q.dack_hi);

    a_r11_hidden_no_hold: assert property (@(posedge clk) disable iff (rst)
        mode_q.policy == POL_HIDDEN |-> !hold_req);

    a_r11_hidden_gating: assert property (@(posedge clk) disable iff (rst)
        busy_byte && mode_q.policy == POL_HIDDEN |-> cpu_idle && dev_req);

    a_r10_demand_gating: assert property (@(posedge clk) disable iff (rst)
        busy_byte && mode_q.policy == POL_DEMAND |-> dev_req);

endmodule

bind dma_xfer_ctl dma_xfer_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hold_req (hold_req),
    .hold_ack (hold_ack),
    .cpu_idle (cpu_idle),
    .dev_req  (dev_req),
    .dev_ack  (dev_ack),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .tc       (tc),
    .mode_q   (mode_q),
    .addr_q   (addr_q),
    .cnt_q    (cnt_q),
    .run_q    (run_q)
);

// File: tb/tb_dma_xfer_ctl.sv
module tb_dma_xfer_ctl;

    localparam int AW = 16;
    localparam int CW = 16;
    localparam int HW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [HW-1:0] reg_wdata = '0;
    logic [HW-1:0] reg_rdata;
    logic          hold_req;
    logic          hold_ack = 1'b0;
    logic          cpu_idle = 1'b0;
    logic          dev_req = 1'b0;
    logic          dev_ack;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic          mem_wr;
    logic          tc;

    int total = 0;
    int bad   = 0;

    // state of the scenario under observation
    bit mon_on = 1'b0;
    int m_pol = 0;
    bit m_dir = 1'b0;
    bit m_ahi = 1'b0;
    int exp_addr = 0;
    int bytes = 0;
    int tcs = 0;
    int tenures = 0;
    bit prev_byte = 1'b0;
    bit prev_hold = 1'b0;

    dma_xfer_ctl #(.ADDR_W(AW), .CNT_W(CW), .HOST_W(HW)) dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hold_req  (hold_req),
        .hold_ack  (hold_ack),
        .cpu_idle  (cpu_idle),
        .dev_req   (dev_req),
        .dev_ack   (dev_ack),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .tc        (tc)
    );

    always #4 clk = ~clk;

    // processor: grants the bus half a cycle after the request, withdraws likewise
    always @(negedge clk) hold_ack <= rst ? 1'b0 : hold_req;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mode_word(int pol, bit dir, bit ahi, bit go);
        return (int'(go) << 4) | (int'(ahi) << 3) | (int'(dir) << 2) | (pol & 3);
    endfunction

    function automatic int wrap_addr(int a);
        return a & ((1 << AW) - 1);
    endfunction

    // byte-cycle monitor, sampled after inputs settle and away from the clock edge
    always begin
        @(negedge clk);
        #1;
        if (!rst && mon_on) begin
            if (mem_rd || mem_wr) begin
                bytes++;
                chk(int'(mem_addr) == exp_addr, "R5", "byte address", mem_addr, exp_addr);
                exp_addr = wrap_addr(exp_addr - 1);
                chk(mem_wr == m_dir && mem_rd == !m_dir, "R5", "strobe vs direction",
                    {mem_wr, mem_rd}, m_dir ? 2 : 1);
                chk(dev_ack == m_ahi, "R6", "ack level on byte", dev_ack, m_ahi);
                if (m_pol != 3)
                    chk(hold_ack == 1'b1, "R4", "grant during byte", hold_ack, 1);
                if (m_pol == 2)
                    chk(dev_req == 1'b1, "R10", "demand byte needs request", dev_req, 1);
                if (m_pol == 3)
                    chk(cpu_idle && dev_req, "R11", "hidden byte gating",
                        {cpu_idle, dev_req}, 3);
            end
            if (m_pol == 1 && prev_byte)
                chk(hold_req == 1'b0, "R9", "release after byte", hold_req, 0);
            if (m_pol == 3 && hold_req)
                chk(1'b0, "R11", "hidden hold", hold_req, 0);
            if (tc) begin
                tcs++;
                chk(prev_byte, "R7", "tc follows last byte", prev_byte, 1);
            end
            if (hold_req && !prev_hold) tenures++;
            prev_byte = mem_rd || mem_wr;
            prev_hold = hold_req;
        end
    end

    task automatic wr(input logic [1:0] sel, input int data);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_sel   = sel;
        reg_wdata = HW'(data);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output int v);
        @(negedge clk);
        reg_sel = sel;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic run_xfer(input int pol, input bit dir, input bit ahi,
                            input int a, input int n, input int pause_at,
                            input bit poke);
        int v;
        bit finished;
        finished = 1'b0;
        wr(2'd3, 1);
        wr(2'd0, a);
        wr(2'd1, n);
        m_pol = pol; m_dir = dir; m_ahi = ahi;
        exp_addr = a; bytes = 0; tcs = 0; tenures = 0;
        prev_byte = 1'b0; prev_hold = 1'b0;
        mon_on = 1'b1;
        wr(2'd2, mode_word(pol, dir, ahi, 1'b1));
        for (int it = 0; it < 3000; it++) begin
            @(negedge clk);
            reg_wr  = 1'b0;
            reg_sel = 2'd3;
            case (pol)
                2: dev_req = (pause_at >= 0 && it >= pause_at && it < pause_at + 8) ? 1'b0
                                                                                   : ($urandom % 4 != 0);
                3: begin dev_req = 1'b1; cpu_idle = $urandom % 2; end
                default: dev_req = 1'b1;
            endcase
            if (poke && it == 2) begin
                // R3: address write while busy must have no effect
                reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h1234;
            end else if (pause_at >= 0 && it == pause_at + 6) begin
                reg_sel = 2'd1;
                #1;
                chk(hold_req == 1'b0, "R10", "bus released in pause", hold_req, 0);
                chk(int'(reg_rdata) == n - bytes, "R10", "count kept in pause",
                    reg_rdata, n - bytes);
            end else begin
                #1;
                if (reg_rdata[0]) begin finished = 1'b1; break; end
            end
        end
        @(negedge clk);
        reg_wr = 1'b0; dev_req = 1'b0; cpu_idle = 1'b0;
        repeat (3) @(negedge clk);
        mon_on = 1'b0;
        chk(finished, "R7", "transfer completes", finished, 1);
        chk(bytes == n, "R5", "byte cycles", bytes, n);
        chk(tcs == 1, "R7", "tc pulses", tcs, 1);
        chk(hold_req == 1'b0, "R7", "hold low after end", hold_req, 0);
        rd(2'd0, v);
        chk(v == wrap_addr(a - n), "R5", "final address", v, wrap_addr(a - n));
        rd(2'd1, v);
        chk(v == 0, "R5", "final count", v, 0);
        rd(2'd3, v);
        chk(v == 1, "R7", "status done not busy", v, 1);
        case (pol)
            0: chk(tenures == 1, "R8", "block tenures", tenures, 1);
            1: chk(tenures == n, "R9", "single tenures", tenures, n);
            2: chk(tenures >= 1, "R10", "demand tenures", tenures, 1);
            default: chk(tenures == 0, "R11", "hidden tenures", tenures, 0);
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(hold_req == 1'b0, "R1", "hold after reset", hold_req, 0);
        chk(!mem_rd && !mem_wr, "R1", "strobes after reset", {mem_rd, mem_wr}, 0);
        chk(tc == 1'b0, "R1", "tc after reset", tc, 0);
        chk(dev_ack == 1'b1, "R1", "ack inactive after reset", dev_ack, 1);
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            chk(v == 0, "R1", "register after reset", v, 0);
        end

        // R2 register readback without starting
        wr(2'd0, 16'hBEEF);
        wr(2'd1, 5);
        wr(2'd2, mode_word(1, 1'b1, 1'b0, 1'b0));
        rd(2'd0, v); chk(v == 16'hBEEF, "R2", "address readback", v, 16'hBEEF);
        rd(2'd1, v); chk(v == 5, "R2", "count readback", v, 5);
        rd(2'd2, v); chk(v == 5, "R2", "mode readback", v, 5);
        rd(2'd3, v); chk(v == 0, "R2", "idle status", v, 0);

        // R3 start with zero count is ignored
        wr(2'd1, 0);
        dev_req = 1'b1;
        wr(2'd2, mode_word(0, 1'b0, 1'b0, 1'b1));
        repeat (5) @(negedge clk);
        #1;
        chk(hold_req == 1'b0, "R3", "no request with zero count", hold_req, 0);
        rd(2'd3, v); chk(v == 0, "R3", "not busy with zero count", v, 0);
        dev_req = 1'b0;

        // R6 polarity when idle with active-high acknowledge
        wr(2'd2, mode_word(0, 1'b0, 1'b1, 1'b0));
        @(negedge clk); #1;
        chk(dev_ack == 1'b0, "R6", "active-high ack idle", dev_ack, 0);

        // directed transfers
        run_xfer(0, 1'b1, 1'b0, 16'h0100, 20, -1, 1'b1);   // R8 block with R3 poke
        run_xfer(1, 1'b0, 1'b1, 16'h0003, 6, -1, 1'b0);    // R9 single, address wraps
        run_xfer(2, 1'b1, 1'b0, 16'h4000, 30, 5, 1'b0);    // R10 demand pause/resume
        run_xfer(3, 1'b0, 1'b0, 16'h0800, 10, -1, 1'b0);   // R11 hidden
        run_xfer(0, 1'b0, 1'b1, 16'h0010, 1, -1, 1'b0);    // single-byte block

        // R2 done clear
        wr(2'd3, 1);
        rd(2'd3, v); chk(v == 0, "R2", "done cleared", v, 0);

        // random transfers
        for (int k = 0; k < 24; k++) begin
            run_xfer(int'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                     int'($urandom % 65536), int'($urandom % 12) + 1, -1, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule